// File: doc/BRIEF.md
# Self-Timed Nonvolatile Memory Access Controller

This block sits between a CPU's register bus and two nonvolatile arrays: a byte-wide data array and a 14-bit-word program array. Both arrays are plain behavioural storage models. Software loads address and data registers through a small register window, then sets a read or a write bit in the control register. Reads finish at once. Writes are erase-then-write operations, and an internal timer, not software, sets how long they take. A busy bit reports an operation in progress, and a sticky completion flag reports its end.

Data-array accesses work on single bytes. The program array is read a word at a time. It is written in aligned four-word blocks: the first three words of a block wait in a staging buffer, and writing the word at offset three erases the whole block and then stores it. Addresses beyond the built size of either array wrap onto the implemented part. A data write aimed past the end of a 128-byte array keeps the pump-enable output low and changes nothing. An input bound shields the low program blocks from writes, but reads of those blocks still work.

Register window (index on `reg_addr`): 0 = control, 1 = data low byte, 2 = data high (6 bits), 3 = address low byte, 4 = address high (5 bits). Control bits: bit0 start read (reads 0), bit1 start write / busy, bit2 space select (0 data, 1 program), bit3 completion flag.

Top module: `nvm_ctrl`

## Requirements
- R1: After reset, every register in the window reads 0x00 and `pump_en` is low.
- R2: Writing the control register with bit0=1, bit1=0 and bit2=0 loads the data-low register from data location (address-low mod DATA_BYTES). The result is readable in the next cycle, and control bit0 always reads 0.
- R3: Writing the control register with bit1=1 and bit2=0 stores the data-low register at the addressed data byte. When the operation ends, control bit3 reads 1.
- R4: A timed write keeps control bit1 at 1 for exactly WR_CYCLES cycles. During an implemented write, `pump_en` is high in each of those cycles and is never high outside them.
- R5: With DATA_BYTES=128, data addresses 0x80 to 0xFF read the location at address mod 128. A write to them still runs the timer and sets bit3, but leaves `pump_en` low and the array unchanged.
- R6: A program read (control bit0=1, bit2=1) uses the 13-bit word address {address-high[4:0], address-low}, taken mod PROG_WORDS. It returns word bits 7:0 in data-low and bits 13:8 in data-high bits 5:0.
- R7: A program write whose word address has low bits other than 11 is buffered. It never sets busy and does not change the array or its read value.
- R8: A program write at a word address whose low bits are 11 erases the aligned four-word block to 0x3FFF, then writes the buffered words and this word. Slots not loaded since the last commit or refusal read 0x3FFF.
- R9: When the block base address is below `wp_bound`, a commit is refused: no busy, bit3 stays 0, the block is unchanged and the staging buffer is cleared. Reads of the block still work.
- R10: While busy, all register writes, including new read and write requests, are ignored.
- R11: Control bit3 stays set across other register writes. Only a control-register write with bit3=0 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on `reg_addr`) |
| wp_bound | input | 13 | Program blocks with a base word address below this value are write-protected |
| pump_en | output | 1 | Erase/write pump enable, high during a timed write to an implemented location |

## Verification
Data bytes go to an implemented location, to a wrapped alias above 0x7F and to a location hit by register traffic while busy. These separate a correct wrap of reads from a write leaking through the alias, and separate frozen registers from ones that kept updating. Program blocks are committed once fully loaded and once with a single buffered word. Comparing the erased slots with the earlier contents shows erase-before-write and shows whether buffered words reached the array early. A protected commit followed by an unprotected one shows whether a refusal really empties the staging buffer. Busy length and pump level are sampled in every busy cycle, so an off-by-one timer or a pump that lags shows up.

// File: rtl/nvm_pkg.sv
`timescale 1ns/1ps
package nvm_pkg;
  // register window indices
  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_DLO  = 3'd1;
  localparam logic [2:0] REG_DHI  = 3'd2;
  localparam logic [2:0] REG_ALO  = 3'd3;
  localparam logic [2:0] REG_AHI  = 3'd4;
  // control bit positions
  localparam int CB_RD   = 0;
  localparam int CB_WR   = 1;
  localparam int CB_SEL  = 2;
  localparam int CB_DONE = 3;
  // widths
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 14;
  localparam int PADR_W  = 13;
  localparam int BLK_N   = 4;
endpackage

// File: rtl/nvm_array.sv
`timescale 1ns/1ps
module nvm_array #(
  parameter int W     = 8,
  parameter int DEPTH = 128,
  parameter int LANES = 1,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_base,
  input  logic [LANES*W-1:0]   wr_data,
  input  logic [AW-1:0]        rd_addr,
  output logic [W-1:0]         rd_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int l = 0; l < LANES; l++) begin
        mem[wr_base + AW'(l)] <= wr_data[l*W +: W];
      end
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/nvm_timer.sv
`timescale 1ns/1ps
module nvm_timer #(
  parameter int CYCLES = 16,
  localparam int CW    = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic finish
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = CW'(CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy   = busy_q;
  assign finish = busy_q && (cnt_q == '0);
endmodule

// File: rtl/nvm_ctrl.sv
`timescale 1ns/1ps
module nvm_ctrl
  import nvm_pkg::*;
#(
  parameter int DATA_BYTES = 128,
  parameter int PROG_WORDS = 4096,
  parameter int WR_CYCLES  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [PADR_W-1:0] wp_bound,
  output logic              pump_en
);
  localparam int DAW = $clog2(DATA_BYTES);
  localparam int PAW = $clog2(PROG_WORDS);
  localparam logic [WORD_W-1:0] ERASED_W = '1;

  // architectural registers
  logic [7:0] dat_lo_q, dat_lo_d;
  logic [5:0] dat_hi_q, dat_hi_d;
  logic [7:0] adr_lo_q, adr_lo_d;
  logic [4:0] adr_hi_q, adr_hi_d;
  logic       psel_q, psel_d;
  logic       done_q, done_d;
  logic       pump_q, pump_d;
  logic [WORD_W-1:0] buf_q [BLK_N];

  // timer
  logic busy, fin, tmr_start;

  // decode
  logic wr_acc, ctrl_wr, go_rd, go_wr, sel_new;
  logic [PADR_W-1:0] padr;
  logic [PAW-1:0]    pidx, pblk;
  logic [1:0]        slot;
  logic [DAW-1:0]    didx;
  logic              d_impl, wp_hit;
  logic              data_go, prog_buf, prog_last, prog_go, prog_refuse;
  logic [WORD_W-1:0] cur_word;

  // array ports
  logic                     d_we, p_we;
  logic [BYTE_W-1:0]        d_wd, d_rd;
  logic [BLK_N*WORD_W-1:0]  p_wd, buf_flat;
  logic [WORD_W-1:0]        p_rd;

  assign wr_acc    = reg_we && !busy;
  assign ctrl_wr   = wr_acc && (reg_addr == REG_CTRL);
  assign sel_new   = reg_wdata[CB_SEL];
  assign go_wr     = ctrl_wr && reg_wdata[CB_WR];
  assign go_rd     = ctrl_wr && reg_wdata[CB_RD] && !reg_wdata[CB_WR];

  assign padr      = {adr_hi_q, adr_lo_q};
  assign pidx      = padr[PAW-1:0];
  assign pblk      = {pidx[PAW-1:2], 2'b00};
  assign slot      = padr[1:0];
  assign didx      = adr_lo_q[DAW-1:0];
  assign d_impl    = ({1'b0, adr_lo_q} < 9'(DATA_BYTES));
  assign wp_hit    = (PADR_W'(pblk) < wp_bound);
  assign cur_word  = {dat_hi_q, dat_lo_q};

  assign data_go     = go_wr && !sel_new;
  assign prog_buf    = go_wr && sel_new && (slot != 2'b11);
  assign prog_last   = go_wr && sel_new && (slot == 2'b11);
  assign prog_go     = prog_last && !wp_hit;
  assign prog_refuse = prog_last && wp_hit;
  assign tmr_start   = data_go || prog_go;

  nvm_timer #(.CYCLES(WR_CYCLES)) tmr_i (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .busy(busy), .finish(fin)
  );

  // data array: erase on start, store on finish (implemented locations only)
  assign d_we = d_impl && (data_go || (fin && !psel_q));
  assign d_wd = fin ? dat_lo_q : {BYTE_W{1'b1}};

  nvm_array #(.W(BYTE_W), .DEPTH(DATA_BYTES), .LANES(1)) darr_i (
    .clk(clk), .wr_en(d_we), .wr_base(didx), .wr_data(d_wd),
    .rd_addr(didx), .rd_data(d_rd)
  );

  // program array: block erase on start, block store on finish
  assign p_we = prog_go || (fin && psel_q);
  assign p_wd = fin ? buf_flat : {BLK_N{ERASED_W}};

  nvm_array #(.W(WORD_W), .DEPTH(PROG_WORDS), .LANES(BLK_N)) parr_i (
    .clk(clk), .wr_en(p_we), .wr_base(pblk), .wr_data(p_wd),
    .rd_addr(pidx), .rd_data(p_rd)
  );

  // staging buffer, one register per block slot
  for (genvar s = 0; s < BLK_N; s++) begin : g_slot
    logic [WORD_W-1:0] slot_d;
    always_comb begin
      slot_d = buf_q[s];
      if (prog_refuse || (fin && psel_q))
        slot_d = ERASED_W;
      else if ((prog_buf || prog_go) && (slot == 2'(s)))
        slot_d = cur_word;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) buf_q[s] <= ERASED_W;
      else        buf_q[s] <= slot_d;
    end
    assign buf_flat[s*WORD_W +: WORD_W] = buf_q[s];
  end

  // next-state for the register window
  always_comb begin
    dat_lo_d = dat_lo_q;
    dat_hi_d = dat_hi_q;
    adr_lo_d = adr_lo_q;
    adr_hi_d = adr_hi_q;
    psel_d   = psel_q;
    done_d   = done_q;
    pump_d   = pump_q;
    if (go_rd) begin
      if (sel_new) begin
        dat_lo_d = p_rd[7:0];
        dat_hi_d = p_rd[13:8];
      end else begin
        dat_lo_d = d_rd;
      end
    end
    if (wr_acc) begin
      case (reg_addr)
        REG_DLO: dat_lo_d = reg_wdata;
        REG_DHI: dat_hi_d = reg_wdata[5:0];
        REG_ALO: adr_lo_d = reg_wdata;
        REG_AHI: adr_hi_d = reg_wdata[4:0];
        default: ;
      endcase
    end
    if (ctrl_wr) begin
      psel_d = sel_new;
      done_d = done_q & reg_wdata[CB_DONE];
    end
    if (tmr_start) pump_d = sel_new || d_impl;
    if (fin) begin
      pump_d = 1'b0;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_lo_q <= '0;
      dat_hi_q <= '0;
      adr_lo_q <= '0;
      adr_hi_q <= '0;
      psel_q   <= 1'b0;
      done_q   <= 1'b0;
      pump_q   <= 1'b0;
    end else begin
      dat_lo_q <= dat_lo_d;
      dat_hi_q <= dat_hi_d;
      adr_lo_q <= adr_lo_d;
      adr_hi_q <= adr_hi_d;
      psel_q   <= psel_d;
      done_q   <= done_d;
      pump_q   <= pump_d;
    end
  end

  always_comb begin
    case (reg_addr)
      REG_CTRL: reg_rdata = {4'b0, done_q, psel_q, busy, 1'b0};
      REG_DLO:  reg_rdata = dat_lo_q;
      REG_DHI:  reg_rdata = {2'b0, dat_hi_q};
      REG_ALO:  reg_rdata = adr_lo_q;
      REG_AHI:  reg_rdata = {3'b0, adr_hi_q};
      default:  reg_rdata = 8'h00;
    endcase
  end

  assign pump_en = pump_q;
endmodule

// File: rtl/nvm_ctrl_chk.sv
`timescale 1ns/1ps
module nvm_ctrl_chk #(
  parameter int DATA_BYTES = 128,
  parameter int PROG_WORDS = 4096,
  parameter int WR_CYCLES  = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        pump_en,
  input logic        psel,
  input logic [7:0]  adr_lo,
  input logic [4:0]  adr_hi,
  input logic [7:0]  dat_lo,
  input logic [5:0]  dat_hi,
  input logic [12:0] wp_bound
);
  localparam int PAW = $clog2(PROG_WORDS);

  int unsigned busy_len;
  logic [12:0] padr;
  logic [12:0] blk_base;
  logic        unimpl;

  assign padr     = {adr_hi, adr_lo};
  assign blk_base = 13'({padr[PAW-1:2], 2'b00});
  assign unimpl   = ({1'b0, adr_lo} >= 9'(DATA_BYTES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= 0;
  end

  assert_busy_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == WR_CYCLES));

  assert_pump_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pump_en |-> busy);

  assert_pump_off_unimpl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !psel && unimpl) |-> !pump_en);

  assert_done_after_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(busy));

  assert_regs_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(dat_lo) && $stable(dat_hi) && $stable(adr_lo) && $stable(adr_hi)));

  assert_protect_refuse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && psel) |-> (blk_base >= $past(wp_bound)));
endmodule

bind nvm_ctrl nvm_ctrl_chk #(
  .DATA_BYTES(DATA_BYTES), .PROG_WORDS(PROG_WORDS), .WR_CYCLES(WR_CYCLES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done_q), .pump_en(pump_en),
  .psel(psel_q), .adr_lo(adr_lo_q), .adr_hi(adr_hi_q), .dat_lo(dat_lo_q),
  .dat_hi(dat_hi_q), .wp_bound(wp_bound)
);

// File: tb/nvm_ctrl_tb_top.sv
`timescale 1ns/1ps
module nvm_ctrl_tb_top;
  localparam int DBYTES = 128;
  localparam int PWORDS = 4096;
  localparam int WRC    = 16;

  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic [12:0] wp_bound;
  logic        pump_en;

  int n_chk;
  int n_err;

  nvm_ctrl #(.DATA_BYTES(DBYTES), .PROG_WORDS(PWORDS), .WR_CYCLES(WRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wp_bound(wp_bound),
    .pump_en(pump_en)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic wait_idle(output int n, output int pump_hi, output int pump_lo);
    logic [7:0] c;
    n = 0; pump_hi = 0; pump_lo = 0;
    for (int i = 0; i < 1000; i++) begin
      peek(3'd0, c);
      if (!c[1]) break;
      n++;
      if (pump_en) pump_hi++; else pump_lo++;
      @(negedge clk);
    end
  endtask

  task automatic data_write(input logic [7:0] a, input logic [7:0] d);
    reg_wr(3'd3, a);
    reg_wr(3'd1, d);
    reg_wr(3'd0, 8'h02);
  endtask

  task automatic data_read(input logic [7:0] a, output logic [7:0] d);
    reg_wr(3'd3, a);
    reg_wr(3'd0, 8'h01);
    peek(3'd1, d);
  endtask

  task automatic prog_write(input logic [12:0] a, input logic [13:0] w);
    reg_wr(3'd4, {3'b0, a[12:8]});
    reg_wr(3'd3, a[7:0]);
    reg_wr(3'd1, w[7:0]);
    reg_wr(3'd2, {2'b0, w[13:8]});
    reg_wr(3'd0, 8'h06);
  endtask

  task automatic prog_read(input logic [12:0] a, output logic [13:0] w);
    logic [7:0] lo, hi;
    reg_wr(3'd4, {3'b0, a[12:8]});
    reg_wr(3'd3, a[7:0]);
    reg_wr(3'd0, 8'h05);
    peek(3'd1, lo);
    peek(3'd2, hi);
    w = {hi[5:0], lo};
  endtask

  task automatic t_reset;
    logic [7:0] v;
    for (int r = 0; r < 5; r++) begin
      peek(3'(r), v);
      check("R1 reset register", {8'h0, v}, 16'h0000);
    end
    check("R1 reset pump", {15'h0, pump_en}, 16'h0000);
  endtask

  task automatic t_data_rw;
    logic [7:0] v; int n, ph, pl;
    data_write(8'h10, 8'h3C);
    wait_idle(n, ph, pl);
    check("R4 busy cycles", 16'(n), 16'(WRC));
    check("R4 pump high while busy", 16'(ph), 16'(WRC));
    check("R4 pump low after write", {15'h0, pump_en}, 16'h0000);
    peek(3'd0, v);
    check("R3 done after data write", {8'h0, v}, 16'h0008);
    reg_wr(3'd1, 8'h00);
    data_read(8'h10, v);
    check("R2 data read", {8'h0, v}, 16'h003C);
    peek(3'd0, v);
    check("R2 read bit reads zero", {15'h0, v[0]}, 16'h0000);
  endtask

  task automatic t_done_sticky;
    logic [7:0] v; int n, ph, pl;
    data_write(8'h11, 8'hA5);
    wait_idle(n, ph, pl);
    reg_wr(3'd3, 8'h12);
    reg_wr(3'd1, 8'h00);
    peek(3'd0, v);
    check("R11 done survives other writes", {8'h0, v}, 16'h0008);
    reg_wr(3'd0, 8'h08);
    peek(3'd0, v);
    check("R11 done kept by bit3=1", {8'h0, v}, 16'h0008);
    reg_wr(3'd0, 8'h00);
    peek(3'd0, v);
    check("R11 done cleared by bit3=0", {8'h0, v}, 16'h0000);
  endtask

  task automatic t_wrap;
    logic [7:0] v; int n, ph, pl;
    data_write(8'h05, 8'h5A);
    wait_idle(n, ph, pl);
    data_write(8'h85, 8'hC3);
    wait_idle(n, ph, pl);
    check("R5 unimplemented write still timed", 16'(n), 16'(WRC));
    check("R5 pump stays low", 16'(ph), 16'h0000);
    peek(3'd0, v);
    check("R5 done after unimplemented write", {8'h0, v}, 16'h0008);
    data_read(8'h85, v);
    check("R5 alias read wraps", {8'h0, v}, 16'h005A);
    data_read(8'h05, v);
    check("R5 base location untouched", {8'h0, v}, 16'h005A);
  endtask

  task automatic t_busy_ignore;
    logic [7:0] v; int n, ph, pl;
    data_write(8'h20, 8'h99);
    reg_wr(3'd1, 8'h11);
    reg_wr(3'd3, 8'h30);
    reg_wr(3'd0, 8'h01);
    wait_idle(n, ph, pl);
    peek(3'd1, v);
    check("R10 data reg frozen", {8'h0, v}, 16'h0099);
    peek(3'd3, v);
    check("R10 address reg frozen", {8'h0, v}, 16'h0020);
    peek(3'd0, v);
    check("R10 control write ignored", {8'h0, v}, 16'h0008);
    data_read(8'h20, v);
    check("R10 written byte intact", {8'h0, v}, 16'h0099);
  endtask

  task automatic t_prog;
    logic [7:0] v; logic [13:0] w; int n, ph, pl;
    prog_write(13'h0040, 14'h1111);
    peek(3'd0, v);
    check("R7 buffered word not busy", {8'h0, v}, 16'h0004);
    prog_write(13'h0041, 14'h2222);
    prog_write(13'h0042, 14'h3333);
    prog_write(13'h0043, 14'h0ABC);
    wait_idle(n, ph, pl);
    check("R8 block commit timed", 16'(n), 16'(WRC));
    peek(3'd0, v);
    check("R8 done after commit", {8'h0, v}, 16'h000C);
    prog_read(13'h0040, w); check("R8 slot0", {2'b0, w}, 16'h1111);
    prog_read(13'h0041, w); check("R8 slot1", {2'b0, w}, 16'h2222);
    prog_read(13'h0042, w); check("R8 slot2", {2'b0, w}, 16'h3333);
    prog_read(13'h0043, w); check("R8 slot3", {2'b0, w}, 16'h0ABC);
    prog_write(13'h0041, 14'h0555);
    peek(3'd0, v);
    check("R7 second buffered word not busy", {8'h0, v}, 16'h0004);
    prog_read(13'h0041, w);
    check("R7 array unchanged by buffered word", {2'b0, w}, 16'h2222);
    prog_write(13'h0043, 14'h0777);
    wait_idle(n, ph, pl);
    prog_read(13'h0040, w); check("R8 unloaded slot erased", {2'b0, w}, 16'h3FFF);
    prog_read(13'h0041, w); check("R8 loaded slot", {2'b0, w}, 16'h0555);
    prog_read(13'h0042, w); check("R8 unloaded slot2 erased", {2'b0, w}, 16'h3FFF);
    prog_read(13'h0043, w); check("R8 last slot", {2'b0, w}, 16'h0777);
    prog_read(13'h1041, w); check("R6 program address wraps", {2'b0, w}, 16'h0555);
    peek(3'd2, v);
    check("R6 high register bits", {8'h0, v}, 16'h0005);
  endtask

  task automatic t_protect;
    logic [7:0] v; logic [13:0] w; int n, ph, pl;
    wp_bound = 13'h0080;
    reg_wr(3'd0, 8'h04);
    prog_write(13'h0041, 14'h0001);
    prog_write(13'h0043, 14'h0002);
    peek(3'd0, v);
    check("R9 refused commit: no busy, no done", {8'h0, v}, 16'h0004);
    check("R9 refused commit: pump low", {15'h0, pump_en}, 16'h0000);
    prog_read(13'h0041, w); check("R9 protected block readable", {2'b0, w}, 16'h0555);
    prog_read(13'h0043, w); check("R9 protected block unchanged", {2'b0, w}, 16'h0777);
    wp_bound = 13'h0000;
    prog_write(13'h0043, 14'h0123);
    wait_idle(n, ph, pl);
    check("R9 unprotected commit timed", 16'(n), 16'(WRC));
    prog_read(13'h0041, w); check("R9 buffer discarded on refusal", {2'b0, w}, 16'h3FFF);
    prog_read(13'h0043, w); check("R9 commit after unprotect", {2'b0, w}, 16'h0123);
  endtask

  initial begin
    n_chk = 0; n_err = 0;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 3'd0; reg_wdata = 8'h00;
    wp_bound = 13'h0000;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_data_rw();
    t_done_sticky();
    t_wrap();
    t_busy_ignore();
    t_prog();
    t_protect();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL all: watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule